// File: doc/BRIEF.md
# Protected Event-Enable Register with Aliased Shadow Windows

This block is a register-bus slave that holds one 32-bit event-enable vector, the bits that tell a DMA engine which incoming events it may act on. Software can reach that vector through two kinds of window. The global window is for supervisor code. Each of eight shadow windows belongs to a region that can be handed to a less trusted requester. Every window maps onto the same flip-flops. The vector itself is read-only. It changes only through a write-one-to-set alias and a write-one-to-clear alias.

Each region has two registers of its own: a protection-attribute word and a bit mask. The attribute word decides which privilege level (user or supervisor) and which requester IDs may read or write through that region's shadow window. The bit mask limits which enable bits the window may see or change. An access that fails its check reads zero and changes nothing. It raises a one-cycle error pulse and records the offending address, requester ID and direction in a status word.

A bus access is presented for one cycle with `bus_valid`. Read data, the response strobe and the error pulse appear on the next cycle. The current enable vector is always driven on `evt_enable` for the engine.

Top module: `shadow_evt_enable`

## Requirements
- R1: After reset the enable vector, every attribute word, every mask and the status word are zero. `err_pulse` and `rsp_valid` are low.
- R2: A write of ones to the global set alias (0x1030) sets those enable bits. A write to an enable-register address (global 0x1020, or shadow offset +0x20) is accepted without error and changes nothing.
- R3: A write of ones to the global clear alias (0x1028) clears those enable bits.
- R4: Shadow region n occupies 0x2000 + n*0x200, with its enable view at +0x20, clear alias at +0x28 and set alias at +0x30. Write data sent through a shadow set alias is ANDed with that region's mask before it is applied. Example: 0xABCD0123 written with mask 0x9FF00FC2 onto a zero vector gives 0x8BC00102.
- R5: A read of a shadow enable view returns the vector ANDed with the region mask. A global read returns the full vector.
- R6: Attribute word n sits at 0x0810 + 4n and uses these bits: 1 user-write, 2 user-read, 4 supervisor-write, 5 supervisor-read. A shadow access whose level bit is 0 is denied, even when its ID is enabled. With attribute 0x4B0, a user write is denied and the vector is unchanged.
- R7: Bits 10+k of the attribute word enable requester ID k, for k from 0 to 5. A shadow access from an ID whose bit is clear, or from an ID of 6 or higher, is denied.
- R8: A denied read returns zero. Every denied access raises `err_pulse` for exactly one cycle.
- R9: The status word at 0x0800 holds the last denied access: bit 20 is the direction (1 = write), bits 19:16 the requester ID and bits 15:0 the byte address.
- R10: User-level accesses to the global enable, set and clear addresses are denied. User-level writes to attribute words and to mask words are also denied. Mask word n sits at 0x0340 + 8n. Attribute words and mask words can be read at either level.
- R11: `rsp_valid` and `rsp_rdata` answer a read exactly one cycle after it is presented. Writes produce no `rsp_valid`.
- R12: A write of ones to a shadow clear alias clears only the bits that are inside the region mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_super | input | 1 | 1 = supervisor level, 0 = user level |
| bus_pid | input | 4 | Requester privilege ID |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| err_pulse | output | 1 | One-cycle pulse for a denied access |
| evt_enable | output | 32 | Current event-enable vector |

## Verification
A wrong attribute or mask word does not stay hidden. On the cycle after the next shadow access, it shows either as an unexpected `err_pulse` or as enable bits outside the mask changing on `evt_enable`. A corrupted enable vector is visible at once on `evt_enable`, and it disagrees between a global read and a shadow read one cycle after each read. A status word that latched the wrong access shows up as a mismatch on the first read of 0x0800 after the denial.

// File: rtl/sevt_pkg.sv
package sevt_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 16;
  localparam int PID_W    = 4;
  localparam int NUM_PID  = 6;

  // attribute bit positions
  localparam int B_UW  = 1;
  localparam int B_UR  = 2;
  localparam int B_SW  = 4;
  localparam int B_SR  = 5;
  localparam int B_ID0 = 10;

  typedef enum logic [2:0] {
    K_NONE, K_EN, K_SET, K_CLR, K_ATTR, K_MASK, K_STAT
  } kind_e;

  // level and ID filter for a shadow access
  function automatic logic perm_ok(input logic [DATA_W-1:0] attr,
                                   input logic wr, input logic sup,
                                   input logic [PID_W-1:0] pid);
    logic lvl;
    logic idok;
    if (sup) lvl = wr ? attr[B_SW] : attr[B_SR];
    else     lvl = wr ? attr[B_UW] : attr[B_UR];
    idok = (int'(pid) < NUM_PID) ? attr[B_ID0 + int'(pid)] : 1'b0;
    return lvl & idok;
  endfunction

  // clear has priority over set on a shared bit
  function automatic logic [DATA_W-1:0] next_enable(input logic [DATA_W-1:0] cur,
                                                    input logic [DATA_W-1:0] setv,
                                                    input logic [DATA_W-1:0] clrv);
    return (cur | setv) & ~clrv;
  endfunction
endpackage

// File: rtl/sevt_decode.sv
module sevt_decode
  import sevt_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int NREG = 8,
  parameter int RIW  = $clog2(NREG)
) (
  input  logic [AW-1:0]  addr,
  output kind_e          kind,
  output logic           shadow,
  output logic [RIW-1:0] idx
);
  localparam logic [AW-1:0] GL_EN    = AW'('h1020);
  localparam logic [AW-1:0] GL_CLR   = AW'('h1028);
  localparam logic [AW-1:0] GL_SET   = AW'('h1030);
  localparam logic [AW-1:0] SH_BASE  = AW'('h2000);
  localparam int            SH_SHIFT = 9;
  localparam logic [AW-1:0] AT_BASE  = AW'('h0810);
  localparam logic [AW-1:0] MK_BASE  = AW'('h0340);
  localparam logic [AW-1:0] ST_ADDR  = AW'('h0800);
  localparam logic [AW-1:0] SH_END   = SH_BASE + AW'(NREG << SH_SHIFT);
  localparam logic [AW-1:0] AT_END   = AT_BASE + AW'(NREG * 4);
  localparam logic [AW-1:0] MK_END   = MK_BASE + AW'(NREG * 8);

  logic [AW-1:0] sh_off, at_off, mk_off;
  logic [8:0]    sh_low;

  always_comb begin
    sh_off = addr - SH_BASE;
    at_off = addr - AT_BASE;
    mk_off = addr - MK_BASE;
    sh_low = sh_off[8:0];
    kind   = K_NONE;
    shadow = 1'b0;
    idx    = '0;
    if (addr == GL_EN)       kind = K_EN;
    else if (addr == GL_CLR) kind = K_CLR;
    else if (addr == GL_SET) kind = K_SET;
    else if (addr == ST_ADDR) kind = K_STAT;
    else if (addr >= SH_BASE && addr < SH_END) begin
      idx = RIW'(sh_off >> SH_SHIFT);
      case (sh_low)
        9'h020: begin kind = K_EN;  shadow = 1'b1; end
        9'h028: begin kind = K_CLR; shadow = 1'b1; end
        9'h030: begin kind = K_SET; shadow = 1'b1; end
        default: kind = K_NONE;
      endcase
    end else if (addr >= AT_BASE && addr < AT_END && addr[1:0] == 2'b00) begin
      kind = K_ATTR;
      idx  = RIW'(at_off >> 2);
    end else if (addr >= MK_BASE && addr < MK_END && addr[2:0] == 3'b000) begin
      kind = K_MASK;
      idx  = RIW'(mk_off >> 3);
    end
  end
endmodule

// File: rtl/sevt_cfg.sv
module sevt_cfg
  import sevt_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NREG = 8,
  parameter int RIW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_attr,
  input  logic           wr_mask,
  input  logic [RIW-1:0] idx,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  attr_sel,
  output logic [DW-1:0]  mask_sel
);
  logic [DW-1:0] attr_q [NREG];
  logic [DW-1:0] mask_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        attr_q[g] <= '0;
        mask_q[g] <= '0;
      end else begin
        if (wr_attr && idx == RIW'(g)) attr_q[g] <= wdata;
        if (wr_mask && idx == RIW'(g)) mask_q[g] <= wdata;
      end
    end
  end

  assign attr_sel = attr_q[idx];
  assign mask_sel = mask_q[idx];
endmodule

// File: rtl/sevt_guard.sv
module sevt_guard
  import sevt_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  kind_e            kind,
  input  logic             shadow,
  input  logic [DW-1:0]    attr,
  input  logic             wr,
  input  logic             sup,
  input  logic [PID_W-1:0] pid,
  output logic             allow
);
  always_comb begin
    unique case (kind)
      K_EN, K_SET, K_CLR: allow = shadow ? perm_ok(attr, wr, sup, pid) : sup;
      K_ATTR, K_MASK:     allow = wr ? sup : 1'b1;
      default:            allow = 1'b1;
    endcase
  end
endmodule

// File: rtl/shadow_evt_enable.sv
module shadow_evt_enable
  import sevt_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int NREG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_super,
  input  logic [PID_W-1:0] bus_pid,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             err_pulse,
  output logic [DW-1:0]    evt_enable
);
  localparam int RIW = $clog2(NREG);

  kind_e          kind;
  logic           is_shadow;
  logic [RIW-1:0] ridx;
  logic [DW-1:0]  cur_attr, cur_mask, win_mask;
  logic           allow, deny, acc_ok, en_wr_hit;
  logic [DW-1:0]  set_vec, clr_vec, rd_val;
  logic [DW-1:0]  en_q, stat_q;

  sevt_decode #(.AW(AW), .NREG(NREG), .RIW(RIW)) u_dec (
    .addr(bus_addr), .kind(kind), .shadow(is_shadow), .idx(ridx)
  );

  sevt_cfg #(.DW(DW), .NREG(NREG), .RIW(RIW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_attr(acc_ok && bus_write && kind == K_ATTR),
    .wr_mask(acc_ok && bus_write && kind == K_MASK),
    .idx(ridx), .wdata(bus_wdata),
    .attr_sel(cur_attr), .mask_sel(cur_mask)
  );

  sevt_guard #(.DW(DW)) u_grd (
    .kind(kind), .shadow(is_shadow), .attr(cur_attr),
    .wr(bus_write), .sup(bus_super), .pid(bus_pid), .allow(allow)
  );

  assign deny      = bus_valid && kind != K_NONE && !allow;
  assign acc_ok    = bus_valid && kind != K_NONE && allow;
  assign en_wr_hit = bus_valid && bus_write && kind == K_EN;
  assign win_mask  = is_shadow ? cur_mask : '1;
  assign set_vec   = (acc_ok && bus_write && kind == K_SET) ? (bus_wdata & win_mask) : '0;
  assign clr_vec   = (acc_ok && bus_write && kind == K_CLR) ? (bus_wdata & win_mask) : '0;

  always_comb begin
    unique case (kind)
      K_EN:    rd_val = en_q & win_mask;
      K_ATTR:  rd_val = cur_attr;
      K_MASK:  rd_val = cur_mask;
      K_STAT:  rd_val = stat_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      stat_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err_pulse <= 1'b0;
    end else begin
      en_q      <= next_enable(en_q, set_vec, clr_vec);
      rsp_valid <= bus_valid && !bus_write;
      rsp_rdata <= (bus_valid && !bus_write && !deny) ? rd_val : '0;
      err_pulse <= deny;
      if (deny) stat_q <= DW'({bus_write, bus_pid, bus_addr});
    end
  end

  assign evt_enable = en_q;
endmodule

// File: rtl/sevt_checker.sv
module sevt_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic          deny,
  input logic          acc_ok,
  input logic          is_shadow,
  input logic          en_wr_hit,
  input logic [DW-1:0] cur_mask,
  input logic [DW-1:0] clr_vec,
  input logic [DW-1:0] evt_enable,
  input logic          err_pulse,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata
);
  p_ro_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_hit |=> $stable(evt_enable));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((evt_enable & $past(clr_vec)) == '0));

  p_mask_fence_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && is_shadow && bus_write) |=>
      (((evt_enable ^ $past(evt_enable)) & ~$past(cur_mask)) == '0));

  p_deny_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (deny && bus_write) |=> $stable(evt_enable));

  p_err_on_deny_r8: assert property (@(posedge clk) disable iff (!rst_n)
    deny |=> err_pulse);

  p_err_only_deny_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !deny |=> !err_pulse);

  p_deny_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && rsp_valid) |-> (rsp_rdata == '0));

  p_rsp_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);

  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rsp_valid);
endmodule

bind shadow_evt_enable sevt_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .deny(deny), .acc_ok(acc_ok), .is_shadow(is_shadow), .en_wr_hit(en_wr_hit),
  .cur_mask(cur_mask), .clr_vec(clr_vec), .evt_enable(evt_enable),
  .err_pulse(err_pulse), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
);

// File: tb/test_shadow_evt_enable.sv
`timescale 1ns/1ps
module test_shadow_evt_enable;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_super = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_pid = '0;
  logic        rsp_valid, err_pulse;
  logic [31:0] rsp_rdata, evt_enable;

  always #2.5 clk = ~clk;

  shadow_evt_enable i_shadow_evt_enable (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_super(bus_super),
    .bus_pid(bus_pid), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .err_pulse(err_pulse), .evt_enable(evt_enable)
  );

  typedef struct {
    int          due;
    bit          is_rd;
    logic [31:0] exp_data;
    bit          exp_err;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access, expected response queued for the monitor
  task automatic acc(bit wr, logic [15:0] a, logic [31:0] d, bit sup, logic [3:0] pid,
                     logic [31:0] exp, bit exp_err, string tag);
    item_t it;
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    bus_super = sup; bus_pid = pid;
    it.due = cyc + 1; it.is_rd = !wr; it.exp_data = exp; it.exp_err = exp_err; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  // monitor: response is due the cycle after the request is sampled (R11)
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        check(err_pulse == it.exp_err, {it.tag, " err_pulse"}, 32'(err_pulse), 32'(it.exp_err));
        check(rsp_valid == it.is_rd, {it.tag, " rsp_valid R11"}, 32'(rsp_valid), 32'(it.is_rd));
        if (it.is_rd)
          check(rsp_rdata == it.exp_data, {it.tag, " rdata"}, rsp_rdata, it.exp_data);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(evt_enable == 0 && !err_pulse && !rsp_valid, "R1 reset outputs", evt_enable, 32'h0);
    rst_n = 1'b1;

    acc(0, 16'h1020, 0, 1, 0, 32'h0, 0, "R1 enable after reset");
    acc(0, 16'h082C, 0, 1, 0, 32'h0, 0, "R1 attr after reset");
    // global set / read-only view
    acc(1, 16'h1030, 32'h0000F0F0, 1, 0, 0, 0, "R2 global set");
    acc(0, 16'h1020, 0, 1, 0, 32'h0000F0F0, 0, "R2 read after set");
    acc(1, 16'h1020, 32'hFFFFFFFF, 1, 0, 0, 0, "R2 write to ro view");
    acc(0, 16'h1020, 0, 1, 0, 32'h0000F0F0, 0, "R2 ro view unchanged");
    // global clear
    acc(1, 16'h1028, 32'h00000030, 1, 0, 0, 0, "R3 global clear");
    acc(0, 16'h1020, 0, 1, 0, 32'h0000F0C0, 0, "R3 read after clear");
    acc(1, 16'h1028, 32'hFFFFFFFF, 1, 0, 0, 0, "R3 clear all");
    // user on global and config
    acc(1, 16'h1030, 32'h0000000F, 0, 0, 0, 1, "R10 user global set denied");
    acc(1, 16'h082C, 32'hFFFFFFFF, 0, 0, 0, 1, "R10 user attr write denied");
    acc(0, 16'h1020, 0, 1, 0, 32'h0, 0, "R10 enable untouched");
    acc(0, 16'h1020, 0, 0, 0, 32'h0, 1, "R10 user global read denied");
    // configure region 7
    acc(1, 16'h082C, 32'h000004B0, 1, 0, 0, 0, "R6 attr7 write");
    acc(1, 16'h0378, 32'h9FF00FC2, 1, 0, 0, 0, "R4 mask7 write");
    acc(0, 16'h082C, 0, 0, 0, 32'h000004B0, 0, "R10 user attr read");
    acc(0, 16'h0378, 0, 0, 0, 32'h9FF00FC2, 0, "R10 user mask read");
    // user write without user-write permission
    acc(1, 16'h2E30, 32'hFF00FF00, 0, 0, 0, 1, "R6 user write denied");
    acc(0, 16'h1020, 0, 1, 0, 32'h0, 0, "R6 enable unchanged");
    acc(0, 16'h0800, 0, 1, 0, 32'h00102E30, 0, "R9 status of denied write");
    acc(1, 16'h2030, 32'h1, 0, 0, 0, 1, "R6 region0 zero attr denied");
    // allow user access
    acc(1, 16'h082C, 32'h000004B6, 1, 0, 0, 0, "R4 attr7 allow user");
    acc(1, 16'h2E30, 32'hABCD0123, 0, 0, 0, 0, "R4 masked shadow set");
    acc(0, 16'h1020, 0, 1, 0, 32'h8BC00102, 0, "R4 masked result");
    acc(1, 16'h1030, 32'h60000001, 1, 0, 0, 0, "R5 global set outside mask");
    acc(0, 16'h2E20, 0, 0, 0, 32'h8BC00102, 0, "R5 shadow read masked");
    acc(0, 16'h1020, 0, 1, 0, 32'hEBC00103, 0, "R5 global read full");
    acc(1, 16'h2E20, 32'hFFFFFFFF, 0, 0, 0, 0, "R2 shadow ro view write");
    acc(0, 16'h1020, 0, 1, 0, 32'hEBC00103, 0, "R2 shadow ro view unchanged");
    // shadow clear limited to mask
    acc(1, 16'h2E28, 32'hFFFFFFFF, 0, 0, 0, 0, "R12 shadow clear");
    acc(0, 16'h1020, 0, 1, 0, 32'h60000001, 0, "R12 outside bits kept");
    // ID filter
    acc(1, 16'h2E30, 32'hFFFFFFFF, 0, 1, 0, 1, "R7 pid1 not enabled");
    acc(1, 16'h2E30, 32'hFFFFFFFF, 1, 6, 0, 1, "R7 pid6 denied");
    acc(0, 16'h0800, 0, 1, 0, 32'h00162E30, 0, "R9 status pid6 write");
    acc(0, 16'h1020, 0, 1, 0, 32'h60000001, 0, "R7 enable unchanged");
    // denied read
    acc(0, 16'h2E20, 0, 0, 1, 32'h0, 1, "R8 denied read zero");
    acc(0, 16'h0800, 0, 1, 0, 32'h00012E20, 0, "R9 status of denied read");

    repeat (3) @(posedge clk);
    #1;
    check(q.size() == 0, "R11 all responses seen", 32'(q.size()), 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule